// File: doc/BRIEF.md
# Vectored Nested-Priority Interrupt Controller

This block collects up to 32 interrupt inputs and presents them to a processor as one request line. Software reaches it through a simple word-addressed register bus. Each source has its own mode register and its own vector register. The mode register holds a 3-bit priority and a trigger type: level or edge, each active high or active low. The vector register holds the word that software gets back when that source is serviced.

Reading the vector-fetch register has side effects. It returns the vector of the best enabled pending source and acknowledges that source. It also pushes the source's priority and number onto a nesting stack. From then on, only a strictly higher priority can raise the request line again. Each write to the end-of-service register pops one stack entry. Because the stacked priorities strictly increase, the stack never holds more than eight entries, and eight end-of-service writes always bring it back to idle. A fetch that finds nothing qualifying returns a programmable spurious word and changes no state.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, these all read zero: the enable mask (0x110), the pending register (0x10C), the current-source register (0x108), every mode register and the spurious word. irq_out is low.
- R2: A write to 0x120 sets the mask bits where the data has ones. A write to 0x124 clears the mask bits where the data has ones. The mask register 0x110 reads back the result.
- R3: In level mode (mode bit 5 = 0), a pending bit follows the input one clock later, active high when mode bit 6 = 0 and active low when it is 1. Software set writes (0x12C) and clear writes (0x128) do not change a level source's pending bit.
- R4: In edge mode (mode bit 5 = 1), a pending bit is set by a rising edge when bit 6 = 0, or by a falling edge when bit 6 = 1. The bit stays set after the input returns. A ones-write to 0x128 clears it and a ones-write to 0x12C sets it.
- R5: irq_out is high exactly when some pending and enabled source has a priority above the top stack entry, or the stack is empty. Bit 0 of the core-status register 0x114 mirrors irq_out.
- R6: Among qualifying sources, the highest priority wins. On equal priority, the lowest source number wins.
- R7: A read of 0x100 while irq_out is high returns the winner's vector register and pushes the winner onto the stack. Register 0x108 then reads that source's number. If the winner is an edge source, its pending bit is cleared.
- R8: A read of 0x100 while irq_out is low returns the spurious word (0x134) and changes no state. Register 0x108 reads zero while the stack is empty.
- R9: Any write to 0x130 pops one stack entry, and does nothing when the stack is empty. The stack holds at most eight entries.
- R10: While a level is active, requests at the same or a lower priority are held off until end-of-service uncovers them.
- R11: A mode register at 4·n returns priority in bits [2:0] and trigger in bits [6:5], with all other bits zero. A vector register at 0x80+4·n reads back as written. The fast-vector word 0x104 reads zero. The debug register 0x138 holds two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt inputs, synchronous to clk |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; marks the vector-fetch side effects |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt request |

## Verification
Directed cases drive each of the four trigger types through its inputs. They show whether pending tracks the input or latches, and whether software set and clear writes reach a level source or are ignored. A tie between two equal-priority edge sources separates lowest-number-wins from any other order. Climbing through all eight priorities fills the stack, which shows the full-stack block and the exact count of pops needed to return to idle. A seeded random mix of set, clear, enable, disable, fetch and end-of-service operations on randomly prioritised sources is compared against a bench reference model of pending bits, mask and stack after every operation.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam logic [11:0] A_VEC_RD = 12'h100;
   localparam logic [11:0] A_FAST   = 12'h104;
   localparam logic [11:0] A_CUR    = 12'h108;
   localparam logic [11:0] A_PEND   = 12'h10C;
   localparam logic [11:0] A_MASK   = 12'h110;
   localparam logic [11:0] A_CORE   = 12'h114;
   localparam logic [11:0] A_EN     = 12'h120;
   localparam logic [11:0] A_DIS    = 12'h124;
   localparam logic [11:0] A_CLR    = 12'h128;
   localparam logic [11:0] A_SET    = 12'h12C;
   localparam logic [11:0] A_EOI    = 12'h130;
   localparam logic [11:0] A_SPUR   = 12'h134;
   localparam logic [11:0] A_DBG    = 12'h138;

   // bit 0: edge sensitive, bit 1: active low
   localparam logic [1:0] TRIG_LVL_HI    = 2'b00;
   localparam logic [1:0] TRIG_EDGE_RISE = 2'b01;
   localparam logic [1:0] TRIG_LVL_LO    = 2'b10;
   localparam logic [1:0] TRIG_EDGE_FALL = 2'b11;
endpackage

// File: rtl/nic_source.sv
module nic_source #(
   parameter int PRIO_W = 3,
   parameter int VEC_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_in,
   input  logic              wr_mode,
   input  logic              wr_vec,
   input  logic [31:0]       wdata,
   input  logic              sw_set,
   input  logic              sw_clr,
   input  logic              ack,
   output logic [PRIO_W-1:0] prio,
   output logic [1:0]        trig,
   output logic [VEC_W-1:0]  vec,
   output logic              pend
);
   logic in_q;
   logic is_edge, low_act, lvl_act, edge_hit;

   assign is_edge  = trig[0];
   assign low_act  = trig[1];
   assign lvl_act  = src_in ^ low_act;
   assign edge_hit = low_act ? (in_q & ~src_in) : (~in_q & src_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio <= '0;
         trig <= nic_pkg::TRIG_LVL_HI;
         vec  <= '0;
         in_q <= 1'b0;
         pend <= 1'b0;
      end else begin
         in_q <= src_in;
         if (wr_mode) begin
            prio <= wdata[PRIO_W-1:0];
            trig <= wdata[6:5];
         end
         if (wr_vec) vec <= wdata[VEC_W-1:0];
         if (!is_edge)                pend <= lvl_act;
         else if (edge_hit || sw_set) pend <= 1'b1;
         else if (sw_clr || ack)      pend <= 1'b0;
      end
   end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
   parameter int N      = 32,
   parameter int PRIO_W = 3,
   parameter int ID_W   = 5
) (
   input  logic [N-1:0]             cand,
   input  logic [N-1:0][PRIO_W-1:0] prio,
   output logic                     found,
   output logic [ID_W-1:0]          win_id,
   output logic [PRIO_W-1:0]        win_prio
);
   // descending scan with >= lets the lower index take a tie
   always_comb begin
      found    = 1'b0;
      win_id   = '0;
      win_prio = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i] && (!found || prio[i] >= win_prio)) begin
            found    = 1'b1;
            win_id   = ID_W'(i);
            win_prio = prio[i];
         end
      end
   end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
   parameter  int PRIO_W = 3,
   parameter  int ID_W   = 5,
   localparam int DEPTH  = 1 << PRIO_W,
   localparam int CNT_W  = PRIO_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_prio,
   input  logic [ID_W-1:0]   push_id,
   output logic [CNT_W-1:0]  depth,
   output logic              empty,
   output logic [PRIO_W-1:0] top_prio,
   output logic [ID_W-1:0]   top_id
);
   logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
   logic [DEPTH-1:0][ID_W-1:0]   id_q;
   logic [PRIO_W-1:0]            top_ix, wr_ix;

   assign empty  = (depth == '0);
   assign top_ix = PRIO_W'(depth - 1'b1);
   assign wr_ix  = PRIO_W'(depth);

   always_comb begin
      top_prio = empty ? '0 : prio_q[top_ix];
      top_id   = empty ? '0 : id_q[top_ix];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth  <= '0;
         prio_q <= '0;
         id_q   <= '0;
      end else if (push && depth != CNT_W'(DEPTH)) begin
         prio_q[wr_ix] <= push_prio;
         id_q[wr_ix]   <= push_id;
         depth         <= depth + 1'b1;
      end else if (pop && !empty) begin
         depth <= depth - 1'b1;
      end
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [11:0]        bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_rd,
   output logic [31:0]        bus_rdata,
   output logic               irq_out
);
   import nic_pkg::*;

   localparam int ID_W  = $clog2(NUM_SRC);
   localparam int CNT_W = PRIO_W + 1;

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_num
      $error("NUM_SRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > 5) begin : g_bad_prio
      $error("PRIO_W must lie in 1..5 to fit below the trigger field");
   end
   if (VEC_W < 1 || VEC_W > 32) begin : g_bad_vec
      $error("VEC_W must lie in 1..32");
   end

   logic                            mode_win, vec_win, ix_ok;
   logic [4:0]                      reg_ix;
   logic [ID_W-1:0]                 sel;
   logic                            en_wr, dis_wr, clr_wr, set_wr, eoi_wr, vec_rd, take;
   logic [NUM_SRC-1:0]              en_q, pend_a, cand;
   logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_a;
   logic [NUM_SRC-1:0][1:0]         trig_a;
   logic [NUM_SRC-1:0][VEC_W-1:0]   vec_a;
   logic [VEC_W-1:0]                spur_q;
   logic [1:0]                      dbg_q;
   logic                            found, empty;
   logic [ID_W-1:0]                 win_id, top_id;
   logic [PRIO_W-1:0]               win_prio, top_prio;
   logic [CNT_W-1:0]                depth_w;

   assign reg_ix   = bus_addr[6:2];
   assign sel      = reg_ix[ID_W-1:0];
   assign ix_ok    = int'(reg_ix) < NUM_SRC;
   assign mode_win = (bus_addr[11:7] == 5'd0) && (bus_addr[1:0] == 2'd0);
   assign vec_win  = (bus_addr[11:7] == 5'd1) && (bus_addr[1:0] == 2'd0);
   assign en_wr    = bus_wr && bus_addr == A_EN;
   assign dis_wr   = bus_wr && bus_addr == A_DIS;
   assign clr_wr   = bus_wr && bus_addr == A_CLR;
   assign set_wr   = bus_wr && bus_addr == A_SET;
   assign eoi_wr   = bus_wr && bus_addr == A_EOI;
   assign vec_rd   = bus_rd && bus_addr == A_VEC_RD;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      nic_source #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_src (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_in  (src_in[i]),
         .wr_mode (bus_wr && mode_win && reg_ix == 5'(i)),
         .wr_vec  (bus_wr && vec_win && reg_ix == 5'(i)),
         .wdata   (bus_wdata),
         .sw_set  (set_wr && bus_wdata[i]),
         .sw_clr  (clr_wr && bus_wdata[i]),
         .ack     (take && win_id == ID_W'(i)),
         .prio    (prio_a[i]),
         .trig    (trig_a[i]),
         .vec     (vec_a[i]),
         .pend    (pend_a[i])
      );
   end

   assign cand = pend_a & en_q;

   nic_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand     (cand),
      .prio     (prio_a),
      .found    (found),
      .win_id   (win_id),
      .win_prio (win_prio)
   );

   assign irq_out = found && (empty || win_prio > top_prio);
   assign take    = vec_rd && irq_out;

   nic_stack #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take),
      .pop       (eoi_wr),
      .push_prio (win_prio),
      .push_id   (win_id),
      .depth     (depth_w),
      .empty     (empty),
      .top_prio  (top_prio),
      .top_id    (top_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         spur_q <= '0;
         dbg_q  <= '0;
      end else begin
         if (en_wr)       en_q <= en_q | bus_wdata[NUM_SRC-1:0];
         else if (dis_wr) en_q <= en_q & ~bus_wdata[NUM_SRC-1:0];
         if (bus_wr && bus_addr == A_SPUR) spur_q <= bus_wdata[VEC_W-1:0];
         if (bus_wr && bus_addr == A_DBG)  dbg_q  <= bus_wdata[1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (mode_win) begin
         if (ix_ok) begin
            bus_rdata[PRIO_W-1:0] = prio_a[sel];
            bus_rdata[6:5]        = trig_a[sel];
         end
      end else if (vec_win) begin
         if (ix_ok) bus_rdata[VEC_W-1:0] = vec_a[sel];
      end else begin
         case (bus_addr)
            A_VEC_RD: bus_rdata[VEC_W-1:0]   = irq_out ? vec_a[win_id] : spur_q;
            A_CUR:    bus_rdata[ID_W-1:0]    = empty ? '0 : top_id;
            A_PEND:   bus_rdata[NUM_SRC-1:0] = pend_a;
            A_MASK:   bus_rdata[NUM_SRC-1:0] = en_q;
            A_CORE:   bus_rdata[0]           = irq_out;
            A_SPUR:   bus_rdata[VEC_W-1:0]   = spur_q;
            A_DBG:    bus_rdata[1:0]         = dbg_q;
            default:  bus_rdata              = '0;
         endcase
      end
   end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
   parameter  int NUM_SRC = 32,
   parameter  int PRIO_W  = 3,
   localparam int DEPTH   = 1 << PRIO_W,
   localparam int CNT_W   = PRIO_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] cand,
   input logic               vec_rd,
   input logic               eoi_wr,
   input logic [CNT_W-1:0]   depth
);
   a_r5_irq_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|cand));

   a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CNT_W'(DEPTH));

   a_r7_fetch_pushes: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && irq_out) |=> depth == $past(depth) + 1'b1);

   a_r8_spurious_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && !irq_out) |=> depth == $past(depth));

   a_r9_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && depth != '0) |=> depth == $past(depth) - 1'b1);

   a_r9_eoi_idle_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && depth == '0) |=> depth == '0);

   a_r10_full_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == CNT_W'(DEPTH)) |-> !irq_out);
endmodule

bind nest_irq_ctrl nic_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_out (irq_out),
   .cand    (cand),
   .vec_rd  (vec_rd),
   .eoi_wr  (eoi_wr),
   .depth   (depth_w)
);

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
   localparam int N = 32;
   localparam logic [31:0] SPUR = 32'h5AFE_0000;
   localparam logic [11:0] A_VEC_RD = 12'h100, A_FAST = 12'h104, A_CUR = 12'h108,
                           A_PEND = 12'h10C, A_MASK = 12'h110, A_CORE = 12'h114,
                           A_EN = 12'h120, A_DIS = 12'h124, A_CLR = 12'h128,
                           A_SET = 12'h12C, A_EOI = 12'h130, A_SPUR = 12'h134,
                           A_DBG = 12'h138;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  src_in;
   logic [11:0]   bus_addr;
   logic          bus_wr, bus_rd;
   logic [31:0]   bus_wdata, bus_rdata;
   logic          irq_out;

   always #2 clk = ~clk;

   nest_irq_ctrl i_nest_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   int checks = 0, errors = 0;
   logic [31:0] d;

   // reference model state for the random phase
   logic [N-1:0] m_pend, m_en;
   int m_prio [N];
   int m_stk_p [8];
   int m_stk_id [8];
   int m_sp;

   function automatic logic [31:0] vec_of(input int n);
      return 32'hA000_0000 + 32'(n * 16) + 32'd3;
   endfunction

   function automatic logic [11:0] mode_a(input int n);
      return 12'(4 * n);
   endfunction

   function automatic int m_win();
      int best = -1;
      for (int i = 0; i < N; i++)
         if (m_pend[i] && m_en[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
      if (best >= 0 && m_sp > 0 && m_prio[best] <= m_stk_p[m_sp-1]) best = -1;
      return best;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] v);
      @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; src_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_out", 32'(irq_out), 0);
      rd(A_MASK, d);     chk("R1 mask", d, 0);
      rd(A_PEND, d);     chk("R1 pending", d, 0);
      rd(A_CUR, d);      chk("R1 current", d, 0);
      rd(mode_a(7), d);  chk("R1 mode", d, 0);
      rd(A_VEC_RD, d);   chk("R1 spurious after reset", d, 0);

      // R11 register readback
      wr(A_SPUR, SPUR);
      for (int i = 0; i < N; i++) wr(12'h080 + 12'(4 * i), vec_of(i));
      rd(12'h080 + 12'd20, d); chk("R11 vector readback", d, vec_of(5));
      rd(A_SPUR, d);           chk("R11 spurious readback", d, SPUR);
      wr(mode_a(3), 32'h65);   rd(mode_a(3), d); chk("R11 mode fields", d, 32'h65);
      wr(mode_a(4), '1);       rd(mode_a(4), d); chk("R11 mode unused bits", d, 32'h67);
      wr(mode_a(3), 0); wr(mode_a(4), 0);
      rd(A_FAST, d);           chk("R11 fast vector", d, 0);
      wr(A_DBG, 3); rd(A_DBG, d); chk("R11 debug set", d, 3);
      wr(A_DBG, 0); rd(A_DBG, d); chk("R11 debug zero", d, 0);

      // R2 enable and disable
      wr(A_EN, 32'h0000_F0F0); wr(A_DIS, 32'h0000_00F0);
      rd(A_MASK, d); chk("R2 mask", d, 32'h0000_F000);
      wr(A_DIS, '1); rd(A_MASK, d); chk("R2 disable all", d, 0);

      // R3 level high on source 2
      wr(mode_a(2), 32'h01); wr(A_EN, 32'h4);
      @(negedge clk); src_in[2] = 1'b1;
      @(negedge clk);
      chk("R3 level high raises irq", 32'(irq_out), 1);
      rd(A_PEND, d); chk("R3 level pending", d, 32'h4);
      wr(A_CLR, 32'h4); rd(A_PEND, d); chk("R3 clear ignored on level", d, 32'h4);
      @(negedge clk); src_in[2] = 1'b0;
      @(negedge clk);
      rd(A_PEND, d); chk("R3 level follows input low", d, 0);
      wr(A_SET, 32'h4); rd(A_PEND, d); chk("R3 set ignored on level", d, 0);
      chk("R3 irq drops", 32'(irq_out), 0);
      // R3 level low on source 6
      wr(mode_a(6), 32'h41);
      rd(A_PEND, d); chk("R3 level low pending", d, 32'h40);
      @(negedge clk); src_in[6] = 1'b1;
      @(negedge clk);
      rd(A_PEND, d); chk("R3 level low released", d, 0);
      wr(mode_a(6), 0); src_in[6] = 1'b0; wr(mode_a(2), 0);
      wr(A_DIS, '1);

      // R4 rising edge on source 8
      wr(mode_a(8), 32'h23);
      @(negedge clk); src_in[8] = 1'b1;
      @(negedge clk); src_in[8] = 1'b0;
      @(negedge clk);
      rd(A_PEND, d); chk("R4 edge latched", d, 32'h100);
      chk("R5 masked source no irq", 32'(irq_out), 0);
      wr(A_EN, 32'h100); chk("R5 enabled source irq", 32'(irq_out), 1);
      wr(A_CLR, 32'h100); rd(A_PEND, d); chk("R4 clear write", d, 0);
      chk("R5 irq after clear", 32'(irq_out), 0);
      wr(A_SET, 32'h100); rd(A_PEND, d); chk("R4 set write", d, 32'h100);
      wr(A_CLR, 32'h100);
      // R4 falling edge on source 9
      wr(mode_a(9), 32'h62);
      @(negedge clk); src_in[9] = 1'b1;
      @(negedge clk);
      rd(A_PEND, d); chk("R4 falling ignores rise", d, 0);
      @(negedge clk); src_in[9] = 1'b0;
      @(negedge clk);
      rd(A_PEND, d); chk("R4 falling edge latched", d, 32'h200);
      wr(A_DIS, '1); wr(A_CLR, '1);

      // R6 R7 R8 R10 arbitration and nesting
      wr(mode_a(10), 32'h24); wr(mode_a(11), 32'h24);
      wr(mode_a(12), 32'h22); wr(mode_a(13), 32'h26);
      wr(A_EN, 32'h3C00); wr(A_SET, 32'h1C00);
      chk("R5 irq with pending", 32'(irq_out), 1);
      rd(A_VEC_RD, d); chk("R6 tie goes to lowest number", d, vec_of(10));
      rd(A_CUR, d);    chk("R7 current source", d, 10);
      rd(A_PEND, d);   chk("R7 edge pending auto cleared", d, 32'h1800);
      chk("R10 equal priority held off", 32'(irq_out), 0);
      rd(A_VEC_RD, d); chk("R8 spurious while held", d, SPUR);
      rd(A_CUR, d);    chk("R8 spurious leaves current", d, 10);
      wr(A_SET, 32'h2000);
      chk("R10 higher priority preempts", 32'(irq_out), 1);
      rd(A_VEC_RD, d); chk("R6 highest priority wins", d, vec_of(13));
      rd(A_CUR, d);    chk("R7 nested current", d, 13);
      wr(A_EOI, 0);
      rd(A_CUR, d);    chk("R9 pop restores level", d, 10);
      chk("R10 still held at level 4", 32'(irq_out), 0);
      wr(A_EOI, 0);
      rd(A_CUR, d);    chk("R8 current zero when idle", d, 0);
      chk("R10 released after pop", 32'(irq_out), 1);
      rd(A_VEC_RD, d); chk("R7 second tie source", d, vec_of(11));
      wr(A_EOI, 0);
      rd(A_VEC_RD, d); chk("R6 lower priority last", d, vec_of(12));
      wr(A_EOI, 0); wr(A_EOI, 0);
      rd(A_CUR, d);    chk("R9 extra pop harmless", d, 0);
      rd(A_VEC_RD, d); chk("R8 spurious when none", d, SPUR);

      // R9 eight-deep nesting
      for (int k = 0; k < 8; k++) wr(mode_a(16 + k), 32'h20 | 32'(k));
      wr(A_EN, 32'h00FF_0000);
      for (int k = 0; k < 8; k++) begin
         wr(A_SET, 32'h1 << (16 + k));
         rd(A_VEC_RD, d); chk("R9 climb fetch", d, vec_of(16 + k));
      end
      rd(A_CUR, d); chk("R9 top of full stack", d, 23);
      wr(A_SET, 32'h0001_0000);
      chk("R10 full stack blocks", 32'(irq_out), 0);
      rd(A_VEC_RD, d); chk("R8 spurious at full", d, SPUR);
      for (int k = 0; k < 7; k++) wr(A_EOI, 0);
      rd(A_CUR, d); chk("R9 seven pops", d, 16);
      wr(A_EOI, 0);
      rd(A_CUR, d); chk("R9 eight pops reach idle", d, 0);
      rd(A_CORE, d); chk("R5 core status mirrors irq", d, 1);
      rd(A_VEC_RD, d); chk("R7 lowest priority after idle", d, vec_of(16));
      for (int k = 0; k < 8; k++) wr(A_EOI, 0);
      rd(A_CUR, d); chk("R9 idle after eight more", d, 0);
      rd(A_CORE, d); chk("R5 core status low", d, 0);

      // random phase against the reference model
      for (int i = 0; i < N; i++) begin
         m_prio[i] = int'($urandom % 8);
         wr(mode_a(i), 32'h20 | 32'(m_prio[i]));
      end
      wr(A_DIS, '1); wr(A_CLR, '1);
      for (int k = 0; k < 8; k++) wr(A_EOI, 0);
      m_pend = '0; m_en = '0; m_sp = 0;
      for (int t = 0; t < 300; t++) begin
         int op;
         int w;
         logic [31:0] r;
         op = int'($urandom % 8);
         r  = $urandom & $urandom & $urandom;
         case (op)
            0, 1: begin wr(A_SET, r); m_pend = m_pend | r; end
            2:    begin wr(A_CLR, r); m_pend = m_pend & ~r; end
            3:    begin r = $urandom; wr(A_EN, r); m_en = m_en | r; end
            4:    begin wr(A_DIS, r); m_en = m_en & ~r; end
            5, 6: begin
               w = m_win();
               rd(A_VEC_RD, d);
               chk("R7 R8 random fetch", d, (w < 0) ? SPUR : vec_of(w));
               if (w >= 0) begin
                  m_stk_p[m_sp] = m_prio[w]; m_stk_id[m_sp] = w; m_sp++;
                  m_pend[w] = 1'b0;
               end
            end
            default: begin
               wr(A_EOI, 0);
               if (m_sp > 0) m_sp--;
               rd(A_CUR, d);
               chk("R9 random current", d, (m_sp > 0) ? 32'(m_stk_id[m_sp-1]) : 0);
            end
         endcase
         chk("R5 random irq_out", 32'(irq_out), (m_win() >= 0) ? 1 : 0);
         rd(A_PEND, d); chk("R4 random pending", d, m_pend);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule